// File: doc/BRIEF.md
# Multilevel Test-Channel Receive Deserializer

This block sits on the device side of a reduced-pin test interface. One test channel arrives as a stream of 4-bit symbols, already decoded from a multilevel analog signal. The block collects these symbols into a 20-bit parallel word that drives scan inputs and primary inputs. The same channel can also run in a binary fallback mode, in which only one bit of each symbol carries data. A full word then takes 20 cycles instead of 5.

A four-bit control input selects the operating mode. Besides the two test modes, there is a converter-tuning mode, which echoes the raw symbol to a capture port. There is also a signature readback mode. Every symbol received in either test mode is folded into a 16-bit signature. The tester later shifts this signature out serially and compares it with its own, which shows whether the data arrived intact or must be applied again. Clock and reset are ordinary binary pins.

Top module: `mlvl_rx_deser`

## Requirements
- R1: `ctl_sel` is decoded with bit 3 = run, bit 2 = wide, bit 1 = tune, bit 0 = narrow. 4'b0010 selects calibration, 4'b11?0 selects multilevel test, 4'b000? selects signature readback and 4'b10?1 selects binary test. Every other value is idle.
- R2: In multilevel test, the k-th symbol after a restart (k = 0..4) lands in `word_out[4k+3:4k]`. After the fifth symbol's clock edge, `word_out` holds the full word and `word_vld` is high for exactly one cycle.
- R3: In binary test, only `sym_in[0]` is used. The k-th bit (k = 0..19) lands in `word_out[k]`, and `word_vld` pulses for one cycle after the twentieth bit.
- R4: After reset the signature is 16'h0000. In each multilevel or binary test cycle, the four bits of `sym_in` are folded in, MSB first. Each step computes fb = sig[15] ^ d, shifts the signature left by one with a zero fill, and XORs in 16'h1021 when fb is 1.
- R5: `sig_out` always shows signature bit 15. Each clock edge in signature readback shifts the signature left by one and fills with zero. Sixteen readback cycles therefore present the signature MSB first.
- R6: In calibration, one clock edge after a symbol is applied, `cal_out` equals that symbol and `cal_vld` is 1. No word is produced and the signature is unchanged.
- R7: In idle, `word_vld` and `cal_vld` stay 0 and the signature is unchanged.
- R8: Any change of decoded mode restarts word assembly, so the next test symbol fills slot 0.
- R9: While reset is low, `word_out`, `word_vld`, `cal_out`, `cal_vld` and `sig_out` are all 0.
- R10: The don't-care bits have no effect. 4'b1110 acts like 4'b1100, 4'b1011 like 4'b1001, and 4'b0001 like 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_sel | input | 4 | Mode control bits (run, wide, tune, narrow) |
| sym_in | input | 4 | Decoded channel symbol |
| word_out | output | 20 | Assembled parallel word |
| word_vld | output | 1 | One-cycle strobe when a word is complete |
| cal_out | output | 4 | Registered raw symbol in calibration |
| cal_vld | output | 1 | High while `cal_out` holds a calibration sample |
| sig_out | output | 1 | Serial signature bit |

## Verification
The embedded assertions check several properties on every cycle. The fill counter stays within bounds and `word_vld` is only ever a single-cycle pulse. A word strobe follows only a test-mode cycle, and a calibration sample is always the previous symbol with no word strobe beside it. The signature is frozen outside the test and readback modes, and readback fills with zero. The bench scenarios show what the assertions cannot: slot placement in both fill ratios, restart after a mid-word mode change, the don't-care codes, and an end-to-end signature readback compared with an independent fold of everything sent.

// File: rtl/mlvl_rx_pkg.sv
package mlvl_rx_pkg;

   typedef enum logic [2:0] {
      MD_IDLE = 3'd0,
      MD_CAL  = 3'd1,
      MD_MLVL = 3'd2,
      MD_CAP  = 3'd3,
      MD_BIN  = 3'd4
   } rx_mode_e;

   // Control bits: [3] run, [2] wide, [1] tune, [0] narrow
   function automatic rx_mode_e decode_ctl(input logic [3:0] c);
      rx_mode_e m;
      casez (c)
         4'b0010: m = MD_CAL;
         4'b11?0: m = MD_MLVL;
         4'b000?: m = MD_CAP;
         4'b10?1: m = MD_BIN;
         default: m = MD_IDLE;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/mlvl_mode_dec.sv
module mlvl_mode_dec
   import mlvl_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] ctl_sel,
   output rx_mode_e   mode,
   output logic       restart
);

   rx_mode_e prev_q;

   always_comb mode = decode_ctl(ctl_sel);

   assign restart = (mode != prev_q);

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= MD_IDLE;
      else        prev_q <= mode;
   end

endmodule

// File: rtl/mlvl_word_asm.sv
module mlvl_word_asm #(
   parameter int WORD_W = 20,
   parameter int SYM_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_mlvl,
   input  logic              en_bin,
   input  logic              restart,
   input  logic [SYM_W-1:0]  sym,
   output logic [WORD_W-1:0] word,
   output logic              vld
);

   localparam int NSLOT     = WORD_W / SYM_W;
   localparam int MLVL_LAST = NSLOT - 1;
   localparam int BIN_LAST  = WORD_W - 1;
   localparam int CNT_W     = $clog2(WORD_W);

   generate
      if (WORD_W % SYM_W != 0) begin : g_bad_ratio
         $error("WORD_W must be a multiple of SYM_W");
      end
      if (NSLOT < 2) begin : g_bad_slots
         $error("word needs at least two symbol slots");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_q, idx;
   logic [WORD_W-1:0] asm_q, asm_nxt;
   logic [NSLOT-1:0]  slot_we;
   logic [WORD_W-1:0] bit_we;
   logic              last;

   assign idx = restart ? '0 : cnt_q;

   // per-slot write enables, one per symbol lane and one per bit lane
   genvar gs, gb;
   generate
      for (gs = 0; gs < NSLOT; gs++) begin : g_slot
         assign slot_we[gs] = en_mlvl && (idx == CNT_W'(gs));
      end
      for (gb = 0; gb < WORD_W; gb++) begin : g_bit
         assign bit_we[gb] = en_bin && (idx == CNT_W'(gb));
      end
   endgenerate

   always_comb begin
      asm_nxt = asm_q;
      for (int s = 0; s < NSLOT; s++)
         if (slot_we[s]) asm_nxt[s*SYM_W +: SYM_W] = sym;
      for (int b = 0; b < WORD_W; b++)
         if (bit_we[b]) asm_nxt[b] = sym[0];
   end

   assign last = (en_mlvl && idx == CNT_W'(MLVL_LAST)) ||
                 (en_bin  && idx == CNT_W'(BIN_LAST));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         asm_q <= '0;
         word  <= '0;
         vld   <= 1'b0;
      end else begin
         asm_q <= asm_nxt;
         vld   <= last;
         if (last) word <= asm_nxt;
         if ((en_mlvl || en_bin) && !last) cnt_q <= idx + 1'b1;
         else                              cnt_q <= '0;
      end
   end

   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(BIN_LAST));

   assert_vld_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      vld |=> !vld);

   assert_vld_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vld |-> $past(en_mlvl || en_bin));

   assert_lane_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_mlvl && en_bin));

endmodule

// File: rtl/mlvl_sig_reg.sv
module mlvl_sig_reg #(
   parameter int              SIG_W = 16,
   parameter int              SYM_W = 4,
   parameter logic [SIG_W-1:0] POLY = 16'h1021
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fold_en,
   input  logic             shift_en,
   input  logic [SYM_W-1:0] sym,
   output logic             sig_msb
);

   generate
      if (SIG_W < SYM_W) begin : g_bad_sig
         $error("signature narrower than a symbol");
      end
   endgenerate

   logic [SIG_W-1:0] sig_q, folded;

   always_comb begin
      logic fb;
      folded = sig_q;
      for (int b = SYM_W - 1; b >= 0; b--) begin
         fb     = folded[SIG_W-1] ^ sym[b];
         folded = {folded[SIG_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        sig_q <= '0;
      else if (fold_en)  sig_q <= folded;
      else if (shift_en) sig_q <= {sig_q[SIG_W-2:0], 1'b0};
   end

   assign sig_msb = sig_q[SIG_W-1];

   assert_sig_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!fold_en && !shift_en) |=> $stable(sig_q));

   assert_fold_shift_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(fold_en && shift_en));

   assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> !sig_q[0]);

endmodule

// File: rtl/mlvl_rx_deser.sv
module mlvl_rx_deser
   import mlvl_rx_pkg::*;
#(
   parameter int               WORD_W = 20,
   parameter int               SYM_W  = 4,
   parameter int               SIG_W  = 16,
   parameter logic [SIG_W-1:0] POLY   = 16'h1021
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        ctl_sel,
   input  logic [SYM_W-1:0]  sym_in,
   output logic [WORD_W-1:0] word_out,
   output logic              word_vld,
   output logic [SYM_W-1:0]  cal_out,
   output logic              cal_vld,
   output logic              sig_out
);

   rx_mode_e mode;
   logic     restart;
   logic     is_mlvl, is_bin, is_cal, is_cap;

   mlvl_mode_dec u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_sel (ctl_sel),
      .mode    (mode),
      .restart (restart)
   );

   assign is_mlvl = (mode == MD_MLVL);
   assign is_bin  = (mode == MD_BIN);
   assign is_cal  = (mode == MD_CAL);
   assign is_cap  = (mode == MD_CAP);

   mlvl_word_asm #(.WORD_W(WORD_W), .SYM_W(SYM_W)) u_asm (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_mlvl (is_mlvl),
      .en_bin  (is_bin),
      .restart (restart),
      .sym     (sym_in),
      .word    (word_out),
      .vld     (word_vld)
   );

   mlvl_sig_reg #(.SIG_W(SIG_W), .SYM_W(SYM_W), .POLY(POLY)) u_sig (
      .clk      (clk),
      .rst_n    (rst_n),
      .fold_en  (is_mlvl || is_bin),
      .shift_en (is_cap),
      .sym      (sym_in),
      .sig_msb  (sig_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cal_out <= '0;
         cal_vld <= 1'b0;
      end else begin
         cal_vld <= is_cal;
         if (is_cal) cal_out <= sym_in;
      end
   end

   assert_cal_echo_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cal_vld |-> (cal_out == $past(sym_in)));

   assert_cal_no_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cal_vld |-> !word_vld);

endmodule

// File: tb/mlvl_rx_deser_test.sv
`timescale 1ns/1ps
module mlvl_rx_deser_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  ctl_sel = 4'b0100;
   logic [3:0]  sym_in = 4'h0;
   logic [19:0] word_out;
   logic        word_vld;
   logic [3:0]  cal_out;
   logic        cal_vld;
   logic        sig_out;

   int checks = 0;
   int failures = 0;
   logic [15:0] msig = 16'h0;
   bit done = 0;

   always #10 clk = ~clk;

   mlvl_rx_deser uut (
      .clk(clk), .rst_n(rst_n), .ctl_sel(ctl_sel), .sym_in(sym_in),
      .word_out(word_out), .word_vld(word_vld), .cal_out(cal_out),
      .cal_vld(cal_vld), .sig_out(sig_out)
   );

   // kind [22:20]: 0 = 1100, 1 = 1110, 2 = 1001, 3 = 1011
   localparam logic [22:0] VEC [6] = '{
      {3'd0, 20'h12345}, {3'd1, 20'hABCDE}, {3'd0, 20'hFFFFF},
      {3'd1, 20'h00000}, {3'd2, 20'h5A5A5}, {3'd3, 20'h80001}
   };

   function automatic logic [15:0] fold(input logic [15:0] s, input logic [3:0] d);
      logic fb;
      for (int b = 3; b >= 0; b--) begin
         fb = s[15] ^ d[b];
         s  = {s[14:0], 1'b0};
         if (fb) s = s ^ 16'h1021;
      end
      return fold_ret(s);
   endfunction

   function automatic logic [15:0] fold_ret(input logic [15:0] s);
      return s;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(input logic [3:0] c, input logic [3:0] s);
      ctl_sel = c;
      sym_in  = s;
      if (rst_n) begin
         if (c[3] && (c[2] ? !c[0] : c[0])) msig = fold(msig, s);
         else if (c[3:1] == 3'b000)         msig = {msig[14:0], 1'b0};
      end
      @(negedge clk);
   endtask

   task automatic send_mlvl(input logic [3:0] c, input logic [19:0] w, input string tag);
      for (int k = 0; k < 5; k++) begin
         tick(c, w[4*k +: 4]);
         if (k == 3) chk({tag, " vld low mid-word"}, word_vld, 1'b0);
      end
      chk({tag, " vld"}, word_vld, 1'b1);
      chk({tag, " word"}, word_out, w);
   endtask

   task automatic send_bin(input logic [3:0] c, input logic [19:0] w, input string tag);
      for (int k = 0; k < 20; k++) begin
         tick(c, {3'b110, w[k]});
         if (k == 18) chk({tag, " vld low mid-word"}, word_vld, 1'b0);
      end
      chk({tag, " vld"}, word_vld, 1'b1);
      chk({tag, " word"}, word_out, w);
   endtask

   task automatic read_sig(input logic [3:0] c, input string tag);
      logic [15:0] exp_sig = msig;
      logic [15:0] got = '0;
      for (int i = 0; i < 16; i++) begin
         got = {got[14:0], sig_out};
         tick(c, 4'h7);
      end
      chk(tag, got, exp_sig);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      tick(4'b1100, 4'hF);
      tick(4'b0010, 4'hA);
      chk("R9 word_out", word_out, 20'h0);
      chk("R9 word_vld", word_vld, 1'b0);
      chk("R9 cal_out", cal_out, 4'h0);
      chk("R9 cal_vld", cal_vld, 1'b0);
      chk("R9 sig_out", sig_out, 1'b0);
      rst_n = 1'b1;

      // R2 R3 R10: table of words
      for (int v = 0; v < 6; v++) begin
         case (VEC[v][22:20])
            3'd0: send_mlvl(4'b1100, VEC[v][19:0], "R2 mlvl");
            3'd1: send_mlvl(4'b1110, VEC[v][19:0], "R10 mlvl alt");
            3'd2: send_bin (4'b1001, VEC[v][19:0], "R3 bin");
            default: send_bin(4'b1011, VEC[v][19:0], "R10 bin alt");
         endcase
      end
      tick(4'b0100, 4'h0);
      chk("R2 vld one cycle", word_vld, 1'b0);

      // R8: partial word, idle gap, then a fresh word
      tick(4'b1100, 4'hF);
      tick(4'b1100, 4'hE);
      tick(4'b0100, 4'h0);
      chk("R7 idle vld", word_vld, 1'b0);
      send_mlvl(4'b1100, 20'h13579, "R8 restart after idle");
      // R8: switch from multilevel to binary mid-word
      tick(4'b1100, 4'h1);
      tick(4'b1100, 4'h2);
      tick(4'b1100, 4'h3);
      send_bin(4'b1001, 20'h0F0F0, "R8 restart into binary");

      // R6: calibration echo
      tick(4'b0010, 4'h9);
      chk("R6 cal_out", cal_out, 4'h9);
      chk("R6 cal_vld", cal_vld, 1'b1);
      chk("R6 no word", word_vld, 1'b0);
      tick(4'b0010, 4'h3);
      chk("R6 cal_out 2", cal_out, 4'h3);
      // R7: undefined codes
      tick(4'b1000, 4'h5);
      chk("R7 cal_vld", cal_vld, 1'b0);
      chk("R7 word_vld", word_vld, 1'b0);
      tick(4'b0111, 4'h6);
      chk("R7 word_vld 2", word_vld, 1'b0);

      // R4 R5 R6 R7: signature readback of all folded data
      read_sig(4'b0001, "R4 R5 signature readback");
      read_sig(4'b0000, "R5 zero fill after readback");

      // R4: single symbol from a zero signature
      tick(4'b1100, 4'h1);
      chk("R4 model single", msig, 16'h1021);
      read_sig(4'b0000, "R4 single-symbol signature");

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule